// File: doc/BRIEF.md
# PC Breakpoint Comparator with Halt Address Capture

This block holds one 13-bit program address. The address is compared with the running program counter on every cycle. When the two are equal, debugging is enabled and the core is not already inside the debug monitor, the block issues a one-cycle halt request to the debug entry sequencer.

The same storage has a second role. When the sequencer signals debug entry, the register is overwritten with the address that the core pushes onto its stack, which is the next instruction to execute. The monitor then reads it back to find where execution stopped. There is no enable bit. Software disables the breakpoint by loading an address inside the monitor's own code region, such as 0x1F00, which user code never reaches.

The register is reached through a byte-wide port. A select input picks the low half or the high half for both writing and reading.

Top module: `pc_brk_capture`

## Requirements
- R1: After reset the stored address is 0x0000, both read selections return 0x00, and `halt_req` is low.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into address bits 7:0. A write with `reg_sel`=1 loads `reg_wdata[4:0]` into address bits 12:8. Each write leaves the other half unchanged and takes effect from the next cycle.
- R3: `reg_rdata` is combinational. With `reg_sel`=0 it returns address bits 7:0. With `reg_sel`=1 it returns address bits 12:8 in bits 4:0, and bits 7:5 read as 0.
- R4: `halt_req` is high for the one cycle after a cycle in which `pc_cur` equals the stored address, `in_debug` is low and `dbg_en_n` is low.
- R5: No halt request follows a cycle in which `in_debug` is high.
- R6: No halt request follows a cycle in which `dbg_en_n` is high (1 means debugging is disabled).
- R7: A match that lasts several consecutive cycles produces only one halt pulse. A further pulse needs at least one non-matching cycle in between.
- R8: When `dbg_entry` is high, `pc_push` is loaded into the address register and is visible from the next cycle.
- R9: When `dbg_entry` and a register write occur in the same cycle, the capture wins and the write is discarded.
- R10: With the address set inside the monitor region, 0x1F00, program counters below that region never cause a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_sel | input | 1 | Half select for both write and read: 0 = low, 1 = high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected half |
| pc_cur | input | 13 | Current program counter |
| pc_push | input | 13 | Program counter value being pushed onto the stack |
| dbg_entry | input | 1 | Debug entry strobe; triggers address capture |
| in_debug | input | 1 | Core is executing the debug monitor |
| dbg_en_n | input | 1 | Debug enable, active low |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The comparator is driven with random program counters, about half of them equal to the address the bench currently models. Mismatches and matches are therefore both exercised, under random settings of `in_debug` and `dbg_en_n`; this separates a correct gating of the match from an unconditional one. Directed runs cover several further cases:
- The program counter is held on the address for several cycles and then left and revisited, which distinguishes a true edge pulse from a level output.
- The reset-vector match against address 0 is tried.
- Capture is combined with a write in the same cycle.
- Program counters are swept across the region below 0x1F00 to confirm the disable-by-address idiom.

// File: rtl/pc_brk_pkg.sv
package pc_brk_pkg;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;

  typedef logic [ADDR_W-1:0] addr_t;

  function automatic logic bp_hit(input addr_t pc, input addr_t bp,
                                  input logic in_dbg, input logic en_n);
    return (pc == bp) && !in_dbg && !en_n;
  endfunction

  function automatic logic [BYTE_W-1:0] bp_read(input addr_t bp, input logic sel);
    logic [BYTE_W-1:0] r;
    r = '0;
    if (sel) r[HI_W-1:0] = bp[ADDR_W-1:BYTE_W];
    else     r = bp[BYTE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pc_brk_reg.sv
module pc_brk_reg
  import pc_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              capture,
  input  addr_t             cap_addr,
  output addr_t             addr_q,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              wr_lo, wr_hi;

  assign wr_lo = wr_en && !sel && !capture;
  assign wr_hi = wr_en &&  sel && !capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (capture) begin
      lo_q <= cap_addr[BYTE_W-1:0];
      hi_q <= cap_addr[ADDR_W-1:BYTE_W];
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata[HI_W-1:0];
    end
  end

  assign addr_q = {hi_q, lo_q};
  assign rdata  = bp_read(addr_q, sel);
endmodule

// File: rtl/pc_brk_match.sv
module pc_brk_match
  import pc_brk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t pc,
  input  addr_t bp,
  input  logic  in_dbg,
  input  logic  en_n,
  output logic  hit_now,
  output logic  pulse
);
  logic hit_prev;

  assign hit_now = bp_hit(pc, bp, in_dbg, en_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_prev <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      hit_prev <= hit_now;
      pulse    <= hit_now && !hit_prev;
    end
  end
endmodule

// File: rtl/pc_brk_capture.sv
module pc_brk_capture
  import pc_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] pc_push,
  input  logic              dbg_entry,
  input  logic              in_debug,
  input  logic              dbg_en_n,
  output logic              halt_req
);
  addr_t bkpt_addr;
  logic  hit_now;

  pc_brk_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .capture  (dbg_entry),
    .cap_addr (pc_push),
    .addr_q   (bkpt_addr),
    .rdata    (reg_rdata)
  );

  pc_brk_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc_cur),
    .bp      (bkpt_addr),
    .in_dbg  (in_debug),
    .en_n    (dbg_en_n),
    .hit_now (hit_now),
    .pulse   (halt_req)
  );
endmodule

// File: rtl/pc_brk_chk.sv
module pc_brk_chk
  import pc_brk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_sel,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] pc_cur,
  input logic [ADDR_W-1:0] pc_push,
  input logic              dbg_entry,
  input logic              in_debug,
  input logic              dbg_en_n,
  input logic              halt_req,
  input logic [ADDR_W-1:0] bkpt_addr
);
  assert_hi_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata[BYTE_W-1:HI_W] == '0);

  assert_hit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(pc_cur) == $past(bkpt_addr));

  assert_no_halt_in_dbg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !$past(in_debug));

  assert_no_halt_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !$past(dbg_en_n));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry |=> bkpt_addr == $past(pc_push));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !dbg_entry) |=> $stable(bkpt_addr));
endmodule

bind pc_brk_capture pc_brk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .pc_cur    (pc_cur),
  .pc_push   (pc_push),
  .dbg_entry (dbg_entry),
  .in_debug  (in_debug),
  .dbg_en_n  (dbg_en_n),
  .halt_req  (halt_req),
  .bkpt_addr (bkpt_addr)
);

// File: tb/pc_brk_capture_test.sv
module pc_brk_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 20240611;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [12:0] pc_cur = '0;
  logic [12:0] pc_push = '0;
  logic        dbg_entry = 1'b0;
  logic        in_debug = 1'b0;
  logic        dbg_en_n = 1'b1;
  logic        halt_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] m_addr = '0;
  logic        m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_brk_capture uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_cur(pc_cur),
    .pc_push(pc_push), .dbg_entry(dbg_entry), .in_debug(in_debug),
    .dbg_en_n(dbg_en_n), .halt_req(halt_req)
  );

  function automatic logic [7:0] exp_read(input logic [12:0] a, input logic s);
    return s ? {3'b000, a[12:8]} : a[7:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic wr, input logic sel, input logic [7:0] wd,
                     input logic [12:0] pc, input logic [12:0] push, input logic ent,
                     input logic indbg, input logic enn, input string htag, input string rtag);
    logic hit, exp_h;
    reg_wr_en = wr; reg_sel = sel; reg_wdata = wd; pc_cur = pc; pc_push = push;
    dbg_entry = ent; in_debug = indbg; dbg_en_n = enn;
    hit = (pc == m_addr) && !indbg && !enn;
    @(posedge clk);
    exp_h = hit && !m_prev;
    m_prev = hit;
    if (ent) m_addr = push;
    else if (wr) begin
      if (sel) m_addr[12:8] = wd[4:0];
      else     m_addr[7:0]  = wd;
    end
    @(negedge clk);
    check(htag, {15'd0, halt_req}, {15'd0, exp_h});
    check(rtag, {8'd0, reg_rdata}, {8'd0, exp_read(m_addr, sel)});
  endtask

  task automatic idle(input logic [12:0] pc, input logic sel, input string t);
    cyc(1'b0, sel, 8'h00, pc, 13'h0, 1'b0, 1'b0, 1'b0, t, t);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(SEED);
    repeat (3) @(negedge clk);
    // R1: reset state
    reg_sel = 1'b0; #1;
    check("R1", {8'd0, reg_rdata}, 16'h0);
    reg_sel = 1'b1; #1;
    check("R1", {8'd0, reg_rdata}, 16'h0);
    check("R1", {15'd0, halt_req}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R4: address 0 matches the reset vector
    idle(13'h0000, 1'b0, "R1");
    idle(13'h0001, 1'b0, "R4");
    // R2/R3: byte writes and reads
    cyc(1'b1, 1'b0, 8'h34, 13'h0100, 13'h0, 1'b0, 1'b0, 1'b0, "R4", "R2");
    cyc(1'b1, 1'b1, 8'hF2, 13'h0100, 13'h0, 1'b0, 1'b0, 1'b0, "R4", "R3");
    idle(13'h0101, 1'b0, "R2");
    // R7: held match gives one pulse, re-entry gives another
    idle(13'h1234, 1'b0, "R4");
    idle(13'h1234, 1'b0, "R7");
    idle(13'h1234, 1'b0, "R7");
    idle(13'h1235, 1'b0, "R7");
    idle(13'h1234, 1'b0, "R7");
    idle(13'h1235, 1'b0, "R7");
    // R5: in_debug blocks
    cyc(1'b0, 1'b0, 8'h0, 13'h1234, 13'h0, 1'b0, 1'b1, 1'b0, "R5", "R5");
    idle(13'h0000, 1'b0, "R5");
    // R6: disabled blocks
    cyc(1'b0, 1'b0, 8'h0, 13'h1234, 13'h0, 1'b0, 1'b0, 1'b1, "R6", "R6");
    idle(13'h0000, 1'b0, "R6");
    // R8: capture
    cyc(1'b0, 1'b1, 8'h0, 13'h0200, 13'h0ABC, 1'b1, 1'b1, 1'b0, "R8", "R8");
    idle(13'h0000, 1'b0, "R8");
    // R9: capture beats write
    cyc(1'b1, 1'b0, 8'h55, 13'h0200, 13'h1765, 1'b1, 1'b1, 1'b0, "R9", "R9");
    idle(13'h0000, 1'b1, "R9");
    idle(13'h0000, 1'b0, "R9");
    // R10: monitor-region address never matches user code
    cyc(1'b1, 1'b0, 8'h00, 13'h0000, 13'h0, 1'b0, 1'b0, 1'b0, "R10", "R10");
    cyc(1'b1, 1'b1, 8'h1F, 13'h0000, 13'h0, 1'b0, 1'b0, 1'b0, "R10", "R10");
    for (int i = 0; i < 200; i++) idle(13'($urandom_range(0, 13'h1EFF)), i[0], "R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic wr, sel, ent, indbg, enn;
      logic [12:0] pc;
      wr    = ($urandom_range(0, 9) == 0);
      sel   = 1'($urandom_range(0, 1));
      ent   = ($urandom_range(0, 19) == 0);
      indbg = ($urandom_range(0, 4) == 0);
      enn   = ($urandom_range(0, 9) == 0);
      pc    = ($urandom_range(0, 1) == 0) ? m_addr : 13'($urandom);
      cyc(wr, sel, 8'($urandom), pc, 13'($urandom), ent, indbg, enn, "R4", "R3");
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule